// File: doc/BRIEF.md
# CPU Interrupt Controller with Halt Wake

This block sits beside a small CPU core. It decides when an interrupt is serviced, which one, where to jump and how many machine cycles the event costs. Five peripheral sources raise single-cycle request pulses. Each pulse latches a bit in a pending-flag register. A software-writable enable register selects which pending flags count. A master enable bit gates the actual service. The core drives it through single-cycle command strobes: enable-all, disable-all, return-from-handler, halt and acknowledge.

A halt stops instruction fetch until any enabled flag is pending. Wake-up depends only on that condition, not on the master enable. A core that woke with the master enable clear therefore resumes fetching without being diverted. When several enabled flags are pending, the lowest-numbered one is served. The vector address and the cycle cost are computed combinationally from the current state.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the master enable is 1, the enable register reads 0x00, the flag register reads 0xE0, `halted_o` is 0 and `take_o` is 0.
- R2: A pulse on `ei_i` or on `reti_i` sets the master enable from the next cycle on.
- R3: A pulse on `di_i` clears the master enable from the next cycle on, and it wins over `ei_i` or `reti_i` in the same cycle.
- R4: A pulse on `halt_i` with no enabled flag pending raises `halted_o` from the next cycle, and it stays high while no enabled flag is pending.
- R5: `halted_o` drops as soon as the AND of enable bits 4:0 and flag bits 4:0 is nonzero, whatever the master enable.
- R6: `take_o` is 1 exactly when the master enable is 1 and the AND of enable bits 4:0 and flag bits 4:0 is nonzero.
- R7: Priority is fixed: the lowest-numbered bit in that AND is chosen, and `vector_o` equals 0x0040 + 8 × bit index (0x40, 0x48, 0x50, 0x58, 0x60).
- R8: `ack_i` while `take_o` is 1 clears the chosen source's flag bit and the master enable in the same edge.
- R9: A request pulse on `req_i[k]` sets flag bit k even when an acknowledge or a flag-register write clears that bit in the same cycle.
- R10: `cost_o` is 5 while `take_o` is 1, otherwise 1 while `halted_o` is 1, otherwise 0.
- R11: A write to the enable register stores all 8 bits. A write to the flag register stores bits 4:0, and bits 7:5 of the flag register always read as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 5 | Request pulses, bit 0 highest priority |
| ie_wr_i | input | 1 | Write `wr_data_i` into the enable register |
| if_wr_i | input | 1 | Write `wr_data_i` into the flag register |
| wr_data_i | input | 8 | Register write data |
| ei_i | input | 1 | Enable-all command strobe |
| di_i | input | 1 | Disable-all command strobe |
| reti_i | input | 1 | Return-from-handler strobe |
| halt_i | input | 1 | Halt command strobe |
| ack_i | input | 1 | Core accepts the offered interrupt |
| ie_o | output | 8 | Enable register contents |
| if_o | output | 8 | Flag register contents, bits 7:5 read as 1 |
| take_o | output | 1 | Interrupt should be serviced now |
| vector_o | output | 16 | Target address of the chosen source |
| halted_o | output | 1 | Fetch stall |
| cost_o | output | 3 | Machine cycles consumed by this step |

## Verification
The assertions check the following on every cycle:
- the master-enable transitions;
- that no service is offered while the master enable is clear;
- that a halted core never coexists with an enabled pending flag;
- that a request always lands in the flag register;
- the cost value during service.

The vector and priority choice for every combination of enable and flag bits is covered by the bench's exhaustive sweep. So are the exact read-back formats and the multi-step stories: halt followed by wake without service, and an acknowledge that races a new request.

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int          NSRC       = 5,
  parameter logic [15:0] VEC_BASE   = 16'h0040,
  parameter int          VEC_STEP   = 8,
  parameter int          SVC_CYCLES = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic            ie_wr_i,
  input  logic            if_wr_i,
  input  logic [7:0]      wr_data_i,
  input  logic            ei_i,
  input  logic            di_i,
  input  logic            reti_i,
  input  logic            halt_i,
  input  logic            ack_i,
  output logic [7:0]      ie_o,
  output logic [7:0]      if_o,
  output logic            take_o,
  output logic [15:0]     vector_o,
  output logic            halted_o,
  output logic [2:0]      cost_o
);
  localparam int IW = $clog2(NSRC);

  logic [7:0]      ie_q;
  logic [NSRC-1:0] if_q;
  logic            ime_q;
  logic            halt_q;
  logic [NSRC-1:0] pend;
  logic            any_pend;
  logic [IW-1:0]   sel;
  logic [NSRC-1:0] clr;
  logic            serve;

  assign pend     = ie_q[NSRC-1:0] & if_q;
  assign any_pend = |pend;
  assign take_o   = ime_q & any_pend;
  assign serve    = take_o & ack_i;

  always_comb begin
    sel = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) sel = IW'(i);
  end

  always_comb begin
    clr = '0;
    if (serve) clr[sel] = 1'b1;
  end

  assign vector_o = VEC_BASE + 16'(VEC_STEP) * 16'(sel);
  assign halted_o = halt_q & ~any_pend;
  assign cost_o   = take_o ? 3'(SVC_CYCLES) : (halted_o ? 3'd1 : 3'd0);
  assign ie_o     = ie_q;
  assign if_o     = {{(8 - NSRC){1'b1}}, if_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= '0;
      if_q   <= '0;
      ime_q  <= 1'b1;
      halt_q <= 1'b0;
    end else begin
      if (ie_wr_i) ie_q <= wr_data_i;
      if_q <= ((if_wr_i ? wr_data_i[NSRC-1:0] : if_q) & ~clr) | req_i;
      if (serve || di_i)       ime_q <= 1'b0;
      else if (ei_i || reti_i) ime_q <= 1'b1;
      halt_q <= (halt_q | halt_i) & ~any_pend;
    end
  end
endmodule

module irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  req_i,
  input logic        ei_i,
  input logic        di_i,
  input logic        reti_i,
  input logic        halt_i,
  input logic        ack_i,
  input logic [7:0]  ie_o,
  input logic [7:0]  if_o,
  input logic        take_o,
  input logic        halted_o,
  input logic [2:0]  cost_o,
  input logic        ime_q
);
  logic [4:0] pend_w;
  assign pend_w = ie_o[4:0] & if_o[4:0];

  a_r2_ei_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((ei_i || reti_i) && !di_i && !(ack_i && take_o)) |=> ime_q);
  a_r3_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
    di_i |=> !ime_q);
  a_r4_halt_enters: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> (halted_o || pend_w != 5'd0));
  a_r5_no_stall_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> pend_w == 5'd0);
  a_r6_gated_by_ime: assert property (@(posedge clk) disable iff (!rst_n)
    !ime_q |-> !take_o);
  a_r8_ack_drops_ime: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && take_o) |=> !ime_q);
  a_r9_request_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != 5'd0) |=> ((if_o[4:0] & $past(req_i)) == $past(req_i)));
  a_r10_service_cost: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> cost_o == 3'd5);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (.*);

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [4:0] req_i = 0;
  logic ie_wr_i = 0, if_wr_i = 0;
  logic [7:0] wr_data_i = 0;
  logic ei_i = 0, di_i = 0, reti_i = 0, halt_i = 0, ack_i = 0;
  logic [7:0] ie_o, if_o;
  logic take_o, halted_o;
  logic [15:0] vector_o;
  logic [2:0] cost_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_ctrl u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    {req_i, ie_wr_i, if_wr_i, ei_i, di_i, reti_i, halt_i, ack_i} = '0;
    @(negedge clk);
  endtask

  task automatic wr_ie(logic [7:0] v);
    @(negedge clk); ie_wr_i = 1; wr_data_i = v;
    @(negedge clk); ie_wr_i = 0;
  endtask

  task automatic wr_if(logic [7:0] v);
    @(negedge clk); if_wr_i = 1; wr_data_i = v;
    @(negedge clk); if_wr_i = 0;
  endtask

  task automatic pulse_ei();
    @(negedge clk); ei_i = 1; @(negedge clk); ei_i = 0;
  endtask

  task automatic pulse_di();
    @(negedge clk); di_i = 1; @(negedge clk); di_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ie", ie_o, 8'h00);
    chk("R1 if", if_o, 8'hE0);
    chk("R1 halted", halted_o, 0);
    chk("R1 take", take_o, 0);
    chk("R1 cost", cost_o, 0);

    wr_ie(8'hA5); chk("R11 ie 8 bits", ie_o, 8'hA5);
    wr_if(8'h0A); chk("R11 if upper ones", if_o, 8'hEA);
    wr_if(8'h00); chk("R11 if clear", if_o, 8'hE0);

    for (int m = 1; m >= 0; m--) begin
      if (m == 1) pulse_ei(); else pulse_di();
      for (int e = 0; e < 32; e++) begin
        wr_ie(8'(e));
        for (int f = 0; f < 32; f++) begin
          int p, idx;
          wr_if(8'(f));
          p = e & f;
          idx = 0;
          for (int b = 4; b >= 0; b--) if (p[b]) idx = b;
          chk("R6 take", take_o, (m == 1 && p != 0) ? 1 : 0);
          chk("R10 cost", cost_o, (m == 1 && p != 0) ? 5 : 0);
          if (p != 0) chk("R7 vector", vector_o, 32'h40 + 8 * idx);
        end
      end
    end

    // R2 via RETI, R3 DI wins over EI
    wr_ie(8'h1F); wr_if(8'h01);
    @(negedge clk); reti_i = 1; @(negedge clk); reti_i = 0;
    chk("R2 reti sets ime", take_o, 1);
    @(negedge clk); ei_i = 1; di_i = 1; @(negedge clk); ei_i = 0; di_i = 0;
    chk("R3 di wins", take_o, 0);
    pulse_ei(); chk("R2 ei sets ime", take_o, 1);

    // R8 acknowledge clears the chosen flag and ime
    wr_if(8'h05);
    chk("R7 pick bit0", vector_o, 16'h0040);
    @(negedge clk); ack_i = 1; @(negedge clk); ack_i = 0;
    chk("R8 flag cleared", if_o, 8'hE4);
    chk("R8 ime cleared", take_o, 0);
    chk("R7 next vector", vector_o, 16'h0050);

    // R9 request beats acknowledge clear
    pulse_ei(); wr_if(8'h02);
    @(negedge clk); ack_i = 1; req_i = 5'h02; @(negedge clk); ack_i = 0; req_i = 0;
    chk("R9 set beats ack", if_o, 8'hE2);
    @(negedge clk); if_wr_i = 1; wr_data_i = 8'h00; req_i = 5'h10;
    @(negedge clk); if_wr_i = 0; req_i = 0;
    chk("R9 set beats write", if_o, 8'hF0);

    // R4/R5 halt and wake with ime clear
    wr_if(8'h00); wr_ie(8'h04); pulse_di();
    @(negedge clk); halt_i = 1; @(negedge clk); halt_i = 0;
    chk("R4 halted", halted_o, 1);
    chk("R10 halt cost", cost_o, 1);
    @(negedge clk); req_i = 5'h08; @(negedge clk); req_i = 0;
    chk("R4 disabled source keeps halt", halted_o, 1);
    @(negedge clk); req_i = 5'h04; @(negedge clk); req_i = 0;
    chk("R5 wake without ime", halted_o, 0);
    chk("R5 no service", take_o, 0);
    chk("R10 cost after wake", cost_o, 0);
    @(negedge clk); halt_i = 1; @(negedge clk); halt_i = 0;
    chk("R4 halt with pending", halted_o, 0);
    idle();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule